// File: doc/BRIEF.md
# Non-Coherent Data Cache with Fence Publishing

This block is a small write-back data cache for one core in a system where hardware keeps no coherence between cores. No snooping or coherence messages exist: data written by this core becomes visible to others only when software issues a release fence. Data written by others becomes visible here only after an acquire fence. Dirty state is held per byte, so a write-back sends only the bytes this core changed, with byte enables. Two cores that modify different bytes of one line therefore merge correctly in memory.

The cache is direct-mapped. By default it has 8 lines of 16 bytes and a 32-bit word interface, and all addresses are word addresses. A miss fills the whole line from memory, one word per beat. Atomic swap and fetch-add bypass the cache and run at memory under a bus lock. Before an atomic runs, any local copy of the target line is written back (dirty bytes only) and dropped. Requests use a one-at-a-time handshake: `req_ready` is high only when the cache is idle, and every request ends with a single `resp_valid` pulse.

Top module: `ncc_cache`

## Requirements
- R1: A read that hits returns the cached word without touching memory. A read miss issues exactly one memory read per word of the line (4 beats by default), then responds with the requested word. A memory request holds its address until it is acknowledged.
- R2: A write (op 1) updates only the bytes whose `req_be` bit is set (bit i covers data bits 8i+7:8i) and marks exactly those bytes dirty. It causes no memory write by itself. A write miss first fills the line.
- R3: A release fence (op 4) writes back every dirty byte in the cache. Each write carries a byte-enable mask equal to the dirty bytes of that word, and words with no dirty bytes are skipped. Lines stay valid afterwards, so later reads of them still hit.
- R4: An acquire fence (op 5) first writes back any dirty bytes, then invalidates every line. A later read therefore fetches fresh data from memory.
- R5: During a fence, `req_ready` stays low from acceptance until the walk over all lines ends. The fence then ends with one `resp_valid` pulse.
- R6: Swap (op 2) and fetch-add (op 3) work on 32-bit words. Each performs a locked memory read, then a locked memory write with all byte enables set, and `mem_lock` stays high from the read through the write. Both return the old value. Swap stores the operand; fetch-add stores old plus operand.
- R7: If an atomic targets a line that is present in the cache, that line's dirty bytes are written back and the line is dropped before the locked read. A later read of that line misses.
- R8: When a miss replaces a valid line that holds dirty bytes, those bytes are written back with their byte enables before the fill starts.
- R9: Two caches that write different bytes of the same word both keep their bytes in memory after each one issues a release fence.
- R10: After reset, `req_ready` is high, `mem_req` and `mem_lock` are low, and no line is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Cache idle and able to take a request |
| req_op | input | 3 | 0 read, 1 write, 2 swap, 3 fetch-add, 4 release, 5 acquire |
| req_waddr | input | WADDR_W (30) | Word address |
| req_wdata | input | 32 | Store data or atomic operand |
| req_be | input | 4 | Byte enables for writes |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Read word or atomic old value |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_waddr | output | WADDR_W (30) | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory write byte enables |
| mem_lock | output | 1 | Bus lock during an atomic |
| mem_ack | input | 1 | Memory accepts or answers the request this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
The assertions check, on every cycle, the invariants that need no scenario. A pending memory request keeps its address. A locked read is always followed by a locked write. A write-back never carries an empty byte mask. A fence drops `req_ready` on the next cycle. A line with dirty bytes is always valid. The bench scenarios cover what only a sequence can show: two caches sharing one memory merge their byte writes, a line stays stale after a release but is refreshed after an acquire, and an atomic on a dirty cached line publishes the dirty bytes before its locked read. The bench also shows that an eviction writes back only the dirty byte of a word.

// File: rtl/ncc_pkg.sv
package ncc_pkg;

   typedef enum logic [2:0] {
      OP_READ  = 3'd0,
      OP_WRITE = 3'd1,
      OP_SWAP  = 3'd2,
      OP_ADD   = 3'd3,
      OP_REL   = 3'd4,
      OP_ACQ   = 3'd5
   } ncc_op_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_LOOK,
      S_WB,
      S_FILL,
      S_WALK,
      S_NEXT,
      S_AMO_RD,
      S_AMO_WR
   } ncc_state_e;

endpackage

// File: rtl/ncc_line_store.sv
module ncc_line_store #(
   parameter int LINES      = 8,
   parameter int LINE_BYTES = 16,
   parameter int WORD_BYTES = 4,
   parameter int TAG_W      = 25
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [$clog2(LINES)-1:0]  idx,
   input  logic [$clog2(LINE_BYTES/WORD_BYTES)-1:0] word_sel,
   output logic                      rd_valid,
   output logic [TAG_W-1:0]          rd_tag,
   output logic [LINE_BYTES-1:0]     rd_dirty,
   output logic [WORD_BYTES*8-1:0]   rd_word,
   input  logic                      wr_en,
   input  logic [WORD_BYTES-1:0]     wr_be,
   input  logic [WORD_BYTES*8-1:0]   wr_data,
   input  logic                      wr_mark,
   input  logic                      install,
   input  logic [TAG_W-1:0]          tag_in,
   input  logic                      clean,
   input  logic                      drop
);

   localparam int BSEL_W = $clog2(WORD_BYTES);
   localparam int OFF_W  = $clog2(LINE_BYTES);

   logic [7:0]            bytes_q [LINES][LINE_BYTES];
   logic                  valid_q [LINES];
   logic [TAG_W-1:0]      tag_q   [LINES];
   logic [LINE_BYTES-1:0] dirty_q [LINES];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int b = 0; b < WORD_BYTES; b++) begin
            if (wr_be[b]) begin
               bytes_q[idx][{word_sel, BSEL_W'(b)}] <= wr_data[8*b +: 8];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int l = 0; l < LINES; l++) begin
            valid_q[l] <= 1'b0;
            tag_q[l]   <= '0;
            dirty_q[l] <= '0;
         end
      end else begin
         if (wr_en && wr_mark) begin
            for (int b = 0; b < WORD_BYTES; b++) begin
               if (wr_be[b]) begin
                  dirty_q[idx][{word_sel, BSEL_W'(b)}] <= 1'b1;
               end
            end
         end
         if (install) begin
            tag_q[idx]   <= tag_in;
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= '0;
         end
         if (clean) begin
            dirty_q[idx] <= '0;
         end
         if (drop) begin
            valid_q[idx] <= 1'b0;
            dirty_q[idx] <= '0;
         end
      end
   end

   assign rd_valid = valid_q[idx];
   assign rd_tag   = tag_q[idx];
   assign rd_dirty = dirty_q[idx];

   for (genvar b = 0; b < WORD_BYTES; b++) begin : g_rd_byte
      localparam logic [BSEL_W-1:0] BS = BSEL_W'(b);
      logic [OFF_W-1:0] pos;
      assign pos = {word_sel, BS};
      assign rd_word[8*b +: 8] = bytes_q[idx][pos];
   end

   for (genvar l = 0; l < LINES; l++) begin : g_line_chk
      assert_dirty_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (dirty_q[l] != '0) |-> valid_q[l]);
   end

endmodule

// File: rtl/ncc_amo_alu.sv
module ncc_amo_alu
   import ncc_pkg::*;
#(
   parameter int W = 32
) (
   input  ncc_op_e        op,
   input  logic [W-1:0]   old_val,
   input  logic [W-1:0]   operand,
   output logic [W-1:0]   new_val
);

   always_comb begin
      if (op == OP_ADD) new_val = old_val + operand;
      else              new_val = operand;
   end

endmodule

// File: rtl/ncc_cache.sv
module ncc_cache
   import ncc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINES      = 8,
   parameter int LINE_BYTES = 16,
   parameter int WORD_BYTES = 4,
   localparam int WORD_W    = WORD_BYTES * 8,
   localparam int BSEL_W    = $clog2(WORD_BYTES),
   localparam int WADDR_W   = ADDR_W - BSEL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [2:0]         req_op,
   input  logic [WADDR_W-1:0] req_waddr,
   input  logic [WORD_W-1:0]  req_wdata,
   input  logic [WORD_BYTES-1:0] req_be,
   output logic               resp_valid,
   output logic [WORD_W-1:0]  resp_rdata,
   output logic               mem_req,
   output logic               mem_we,
   output logic [WADDR_W-1:0] mem_waddr,
   output logic [WORD_W-1:0]  mem_wdata,
   output logic [WORD_BYTES-1:0] mem_be,
   output logic               mem_lock,
   input  logic               mem_ack,
   input  logic [WORD_W-1:0]  mem_rdata
);

   localparam int WPL    = LINE_BYTES / WORD_BYTES;
   localparam int WSEL_W = $clog2(WPL);
   localparam int IDX_W  = $clog2(LINES);
   localparam int TAG_W  = WADDR_W - WSEL_W - IDX_W;

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (WORD_BYTES != 4) begin : g_bad_word
      $error("the core interface is 32 bits wide");
   end
   if (WPL < 2 || (WPL & (WPL - 1)) != 0 || LINE_BYTES % WORD_BYTES != 0) begin : g_bad_line
      $error("LINE_BYTES must hold a power of two of at least 2 words");
   end

   ncc_state_e           st_q, ret_q;
   ncc_op_e              op_q;
   logic [WADDR_W-1:0]   waddr_q;
   logic [WORD_W-1:0]    wdata_q, old_q, resp_data_q;
   logic [WORD_BYTES-1:0] be_q;
   logic [IDX_W-1:0]     walk_q;
   logic [WSEL_W-1:0]    wcnt_q;
   logic                 drop_q, resp_q;

   logic [TAG_W-1:0]     a_tag;
   logic [IDX_W-1:0]     a_idx, s_idx;
   logic [WSEL_W-1:0]    a_wsel, s_wsel;
   logic                 fence_q, hit, wb_last, wb_step;
   logic                 l_valid;
   logic [TAG_W-1:0]     l_tag;
   logic [LINE_BYTES-1:0] l_dirty;
   logic [WORD_W-1:0]    l_word, amo_new;
   logic [WORD_BYTES-1:0] wmask;

   logic                 st_wr_en, st_mark, st_install, st_clean, st_drop;
   logic [WORD_BYTES-1:0] st_be;
   logic [WORD_W-1:0]    st_data;

   assign a_tag   = waddr_q[WADDR_W-1 -: TAG_W];
   assign a_idx   = waddr_q[WSEL_W +: IDX_W];
   assign a_wsel  = waddr_q[WSEL_W-1:0];
   assign fence_q = (op_q == OP_REL) || (op_q == OP_ACQ);
   assign s_idx   = fence_q ? walk_q : a_idx;
   assign s_wsel  = (st_q == S_LOOK) ? a_wsel : wcnt_q;
   assign hit     = l_valid && (l_tag == a_tag);
   assign wmask   = l_dirty[{wcnt_q, {BSEL_W{1'b0}}} +: WORD_BYTES];
   assign wb_last = (wcnt_q == WSEL_W'(WPL - 1));
   assign wb_step = (wmask == '0) || mem_ack;

   ncc_line_store #(
      .LINES(LINES), .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES), .TAG_W(TAG_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .idx(s_idx), .word_sel(s_wsel),
      .rd_valid(l_valid), .rd_tag(l_tag), .rd_dirty(l_dirty), .rd_word(l_word),
      .wr_en(st_wr_en), .wr_be(st_be), .wr_data(st_data), .wr_mark(st_mark),
      .install(st_install), .tag_in(a_tag), .clean(st_clean), .drop(st_drop)
   );

   ncc_amo_alu #(.W(WORD_W)) u_alu (
      .op(op_q), .old_val(old_q), .operand(wdata_q), .new_val(amo_new)
   );

   // memory port
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_lock  = 1'b0;
      mem_be    = '0;
      mem_wdata = '0;
      mem_waddr = '0;
      unique case (st_q)
         S_WB: begin
            if (wmask != '0) begin
               mem_req   = 1'b1;
               mem_we    = 1'b1;
               mem_waddr = {l_tag, s_idx, wcnt_q};
               mem_wdata = l_word;
               mem_be    = wmask;
            end
         end
         S_FILL: begin
            mem_req   = 1'b1;
            mem_waddr = {a_tag, a_idx, wcnt_q};
         end
         S_AMO_RD: begin
            mem_req   = 1'b1;
            mem_lock  = 1'b1;
            mem_waddr = waddr_q;
         end
         S_AMO_WR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_lock  = 1'b1;
            mem_waddr = waddr_q;
            mem_wdata = amo_new;
            mem_be    = '1;
         end
         default: ;
      endcase
   end

   // line store controls
   always_comb begin
      st_wr_en   = 1'b0;
      st_mark    = 1'b0;
      st_be      = '0;
      st_data    = '0;
      st_install = 1'b0;
      st_clean   = 1'b0;
      st_drop    = 1'b0;
      unique case (st_q)
         S_LOOK: begin
            if (op_q == OP_WRITE && hit) begin
               st_wr_en = 1'b1;
               st_mark  = 1'b1;
               st_be    = be_q;
               st_data  = wdata_q;
            end
         end
         S_FILL: begin
            if (mem_ack) begin
               st_wr_en   = 1'b1;
               st_be      = '1;
               st_data    = mem_rdata;
               st_install = wb_last;
            end
         end
         S_WB: begin
            if (wb_step && wb_last) begin
               st_drop  = drop_q;
               st_clean = !drop_q;
            end
         end
         default: ;
      endcase
   end

   // sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= S_IDLE;
         ret_q       <= S_IDLE;
         op_q        <= OP_READ;
         waddr_q     <= '0;
         wdata_q     <= '0;
         be_q        <= '0;
         old_q       <= '0;
         walk_q      <= '0;
         wcnt_q      <= '0;
         drop_q      <= 1'b0;
         resp_q      <= 1'b0;
         resp_data_q <= '0;
      end else begin
         resp_q <= 1'b0;
         unique case (st_q)
            S_IDLE: begin
               if (req_valid) begin
                  op_q    <= ncc_op_e'(req_op);
                  waddr_q <= req_waddr;
                  wdata_q <= req_wdata;
                  be_q    <= req_be;
                  st_q    <= S_LOOK;
               end
            end
            S_LOOK: begin
               wcnt_q <= '0;
               unique case (op_q)
                  OP_READ, OP_WRITE: begin
                     if (hit) begin
                        resp_q      <= 1'b1;
                        resp_data_q <= (op_q == OP_READ) ? l_word : '0;
                        st_q        <= S_IDLE;
                     end else if (l_valid && l_dirty != '0) begin
                        ret_q  <= S_FILL;
                        drop_q <= 1'b0;
                        st_q   <= S_WB;
                     end else begin
                        st_q <= S_FILL;
                     end
                  end
                  OP_SWAP, OP_ADD: begin
                     if (hit) begin
                        ret_q  <= S_AMO_RD;
                        drop_q <= 1'b1;
                        st_q   <= S_WB;
                     end else begin
                        st_q <= S_AMO_RD;
                     end
                  end
                  default: begin
                     walk_q <= '0;
                     st_q   <= S_WALK;
                  end
               endcase
            end
            S_WALK: begin
               if (l_valid && (l_dirty != '0 || op_q == OP_ACQ)) begin
                  ret_q  <= S_NEXT;
                  drop_q <= (op_q == OP_ACQ);
                  wcnt_q <= '0;
                  st_q   <= S_WB;
               end else begin
                  st_q <= S_NEXT;
               end
            end
            S_NEXT: begin
               if (walk_q == IDX_W'(LINES - 1)) begin
                  resp_q      <= 1'b1;
                  resp_data_q <= '0;
                  st_q        <= S_IDLE;
               end else begin
                  walk_q <= walk_q + 1'b1;
                  st_q   <= S_WALK;
               end
            end
            S_WB: begin
               if (wb_step) begin
                  if (wb_last) begin
                     wcnt_q <= '0;
                     st_q   <= ret_q;
                  end else begin
                     wcnt_q <= wcnt_q + 1'b1;
                  end
               end
            end
            S_FILL: begin
               if (mem_ack) begin
                  if (wb_last) begin
                     wcnt_q <= '0;
                     st_q   <= S_LOOK;
                  end else begin
                     wcnt_q <= wcnt_q + 1'b1;
                  end
               end
            end
            S_AMO_RD: begin
               if (mem_ack) begin
                  old_q <= mem_rdata;
                  st_q  <= S_AMO_WR;
               end
            end
            S_AMO_WR: begin
               if (mem_ack) begin
                  resp_q      <= 1'b1;
                  resp_data_q <= old_q;
                  st_q        <= S_IDLE;
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign req_ready  = (st_q == S_IDLE);
   assign resp_valid = resp_q;
   assign resp_rdata = resp_data_q;

   assert_req_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_waddr) && $stable(mem_we)));

   assert_lock_span_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_lock && !mem_we && mem_ack) |=> (mem_req && mem_lock && mem_we));

   assert_wb_mask_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && !mem_lock) |-> (mem_be != '0));

   assert_fence_blocks_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (req_op == 3'd4 || req_op == 3'd5)) |=> !req_ready);

   assert_idle_no_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_lock);

endmodule

// File: tb/tb_ncc_cache.sv
module tb_ncc_cache;

   localparam int WA = 30;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          req_valid [2];
   logic          req_ready [2];
   logic [2:0]    req_op [2];
   logic [WA-1:0] req_waddr [2];
   logic [31:0]   req_wdata [2];
   logic [3:0]    req_be [2];
   logic          resp_valid [2];
   logic [31:0]   resp_rdata [2];
   logic          mem_req [2];
   logic          mem_we [2];
   logic [WA-1:0] mem_waddr [2];
   logic [31:0]   mem_wdata [2];
   logic [3:0]    mem_be [2];
   logic          mem_lock [2];
   logic          mem_ack [2];
   logic [31:0]   mem_rdata [2];

   ncc_cache dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid[0]), .req_ready(req_ready[0]), .req_op(req_op[0]),
      .req_waddr(req_waddr[0]), .req_wdata(req_wdata[0]), .req_be(req_be[0]),
      .resp_valid(resp_valid[0]), .resp_rdata(resp_rdata[0]),
      .mem_req(mem_req[0]), .mem_we(mem_we[0]), .mem_waddr(mem_waddr[0]),
      .mem_wdata(mem_wdata[0]), .mem_be(mem_be[0]), .mem_lock(mem_lock[0]),
      .mem_ack(mem_ack[0]), .mem_rdata(mem_rdata[0])
   );

   ncc_cache dut_b (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid[1]), .req_ready(req_ready[1]), .req_op(req_op[1]),
      .req_waddr(req_waddr[1]), .req_wdata(req_wdata[1]), .req_be(req_be[1]),
      .resp_valid(resp_valid[1]), .resp_rdata(resp_rdata[1]),
      .mem_req(mem_req[1]), .mem_we(mem_we[1]), .mem_waddr(mem_waddr[1]),
      .mem_wdata(mem_wdata[1]), .mem_be(mem_be[1]), .mem_lock(mem_lock[1]),
      .mem_ack(mem_ack[1]), .mem_rdata(mem_rdata[1])
   );

   // shared memory model
   logic [31:0] memw [256];
   int owner = 0;

   function automatic logic [31:0] iv(input int w);
      return (32'(w) * 32'h0103_0507) ^ 32'hA5C3_1E00;
   endfunction

   always_comb begin
      mem_ack[0] = mem_req[0] && owner != 2;
      mem_ack[1] = mem_req[1] && !mem_ack[0] && owner != 1;
   end
   assign mem_rdata[0] = memw[mem_waddr[0][7:0]];
   assign mem_rdata[1] = memw[mem_waddr[1][7:0]];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) memw[i] <= iv(i);
         owner <= 0;
      end else begin
         for (int c = 0; c < 2; c++) begin
            if (mem_ack[c]) begin
               if (mem_we[c]) begin
                  for (int b = 0; b < 4; b++)
                     if (mem_be[c][b]) memw[mem_waddr[c][7:0]][8*b +: 8] <= mem_wdata[c][8*b +: 8];
               end
               if (mem_lock[c]) owner <= mem_we[c] ? 0 : c + 1;
            end
         end
      end
   end

   int checks = 0;
   int errors = 0;
   int rd_cnt [2];
   int wr_cnt [2];
   logic [3:0] be_last [2];
   logic lock_prev [2];
   int fence_bad = 0;
   int cyc = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // per-cycle monitor of both memory ports
   always @(negedge clk) begin
      if (rst_n) begin
         for (int c = 0; c < 2; c++) begin
            if (lock_prev[c]) check("R6 lock held into write", {29'd0, mem_req[c], mem_lock[c], mem_we[c]}, 32'd7);
            if (mem_ack[c] && mem_we[c] && !mem_lock[c]) check("R3 write-back mask nonzero", 32'(mem_be[c] != 4'd0), 32'd1);
            lock_prev[c] = mem_ack[c] && mem_lock[c] && !mem_we[c];
            if (mem_ack[c]) begin
               if (mem_we[c]) begin wr_cnt[c]++; be_last[c] = mem_be[c]; end
               else rd_cnt[c]++;
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic xact(input int c, input logic [2:0] op, input logic [WA-1:0] wa,
                       input logic [31:0] d, input logic [3:0] be, output logic [31:0] rd);
      @(negedge clk);
      while (!req_ready[c]) @(negedge clk);
      req_valid[c] = 1'b1;
      req_op[c]    = op;
      req_waddr[c] = wa;
      req_wdata[c] = d;
      req_be[c]    = be;
      @(negedge clk);
      req_valid[c] = 1'b0;
      while (!resp_valid[c]) begin
         if ((op == 3'd4 || op == 3'd5) && req_ready[c]) fence_bad++;
         @(negedge clk);
      end
      rd = resp_rdata[c];
   endtask

   initial begin
      logic [31:0] r;
      int r0, w0, r1, w1;
      for (int c = 0; c < 2; c++) begin
         req_valid[c] = 0; req_op[c] = 0; req_waddr[c] = 0; req_wdata[c] = 0; req_be[c] = 0;
         rd_cnt[c] = 0; wr_cnt[c] = 0; be_last[c] = 0; lock_prev[c] = 0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 ready A", 32'(req_ready[0]), 1);
      check("R10 ready B", 32'(req_ready[1]), 1);
      check("R10 mem idle", {30'd0, mem_req[0] | mem_req[1], mem_lock[0] | mem_lock[1]}, 0);

      // R1 read miss then hit
      r0 = rd_cnt[0];
      xact(0, 3'd0, 30'd17, 0, 0, r);
      check("R1 miss data", r, iv(17));
      check("R1 fill beats", 32'(rd_cnt[0] - r0), 4);
      r0 = rd_cnt[0];
      xact(0, 3'd1 - 3'd1, 30'd18, 0, 0, r);
      check("R1 hit data", r, iv(18));
      check("R1 hit no memory", 32'(rd_cnt[0] - r0), 0);

      // R2 byte writes stay local
      xact(1, 3'd0, 30'd16, 0, 0, r);
      check("R1 core B fill", r, iv(16));
      w0 = wr_cnt[0]; w1 = wr_cnt[1];
      xact(0, 3'd1, 30'd17, 32'h0000_00AA, 4'b0001, r);
      xact(1, 3'd1, 30'd17, 32'h00BB_0000, 4'b0100, r);
      check("R2 no memory writes", 32'(wr_cnt[0] - w0 + wr_cnt[1] - w1), 0);
      xact(0, 3'd0, 30'd17, 0, 0, r);
      check("R2 byte merge local", r, {iv(17)[31:8], 8'hAA});

      // R3 / R9 releases
      w0 = wr_cnt[0];
      xact(0, 3'd4, 0, 0, 0, r);
      check("R3 A release writes", 32'(wr_cnt[0] - w0), 1);
      check("R3 A release mask", 32'(be_last[0]), 32'h1);
      w1 = wr_cnt[1];
      xact(1, 3'd4, 0, 0, 0, r);
      check("R3 B release mask", 32'(be_last[1]), 32'h4);
      check("R3 B release writes", 32'(wr_cnt[1] - w1), 1);
      check("R9 both bytes survive", memw[17], {iv(17)[31:24], 8'hBB, iv(17)[15:8], 8'hAA});
      r0 = rd_cnt[0];
      xact(0, 3'd0, 30'd17, 0, 0, r);
      check("R3 line stays valid", 32'(rd_cnt[0] - r0), 0);
      check("R3 no remote view yet", r, {iv(17)[31:8], 8'hAA});
      check("R5 ready low in fences", 32'(fence_bad), 0);

      // R4 acquire
      xact(0, 3'd5, 0, 0, 0, r);
      r0 = rd_cnt[0];
      xact(0, 3'd0, 30'd17, 0, 0, r);
      check("R4 refetch after acquire", 32'(rd_cnt[0] - r0), 4);
      check("R4 remote write visible", r, {iv(17)[31:24], 8'hBB, iv(17)[15:8], 8'hAA});
      xact(0, 3'd1, 30'd16, 32'h1122_3344, 4'hF, r);
      w0 = wr_cnt[0];
      xact(0, 3'd5, 0, 0, 0, r);
      check("R4 acquire writes dirty", 32'(wr_cnt[0] - w0), 1);
      check("R4 acquire published", memw[16], 32'h1122_3344);
      r0 = rd_cnt[0];
      xact(0, 3'd0, 30'd16, 0, 0, r);
      check("R4 reread data", r, 32'h1122_3344);
      check("R4 reread from memory", 32'(rd_cnt[0] - r0), 4);

      // R6 / R7 atomics
      xact(1, 3'd1, 30'd18, 32'h0000_5566, 4'b0011, r);
      xact(0, 3'd2, 30'd18, 32'hCAFE_F00D, 0, r);
      check("R6 swap old value", r, iv(18));
      check("R6 swap stored", memw[18], 32'hCAFE_F00D);
      w1 = wr_cnt[1];
      xact(1, 3'd3, 30'd18, 32'd1, 0, r);
      check("R7 dirty bytes before atomic", r, 32'hCAFE_5566);
      check("R6 fetch-add stored", memw[18], 32'hCAFE_5567);
      check("R7 write-back plus atomic", 32'(wr_cnt[1] - w1), 2);
      r1 = rd_cnt[1];
      xact(1, 3'd0, 30'd18, 0, 0, r);
      check("R7 line dropped", 32'(rd_cnt[1] - r1), 4);
      check("R7 reread value", r, 32'hCAFE_5567);

      // R8 eviction of dirty line
      xact(0, 3'd1, 30'd19, 32'h7700_0000, 4'b1000, r);
      w0 = wr_cnt[0]; r0 = rd_cnt[0];
      xact(0, 3'd0, 30'd49, 0, 0, r);
      check("R8 evict writes", 32'(wr_cnt[0] - w0), 1);
      check("R8 evict mask", 32'(be_last[0]), 32'h8);
      check("R8 evict data", memw[19], {8'h77, iv(19)[23:0]});
      check("R8 new line data", r, iv(49));
      check("R8 new line beats", 32'(rd_cnt[0] - r0), 4);
      check("R5 ready low in fences", 32'(fence_bad), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule